// File: doc/BRIEF.md
# Clock Period Jitter Monitor

The monitor characterises a slow test clock against a much faster sampling clock. The test clock enters through a synchronizer, and each rising edge is detected in the sampling domain. The time between two successive rising edges is one period, measured in whole sampling ticks. The falling edge in between splits that period into a high time and a low time. A start pulse clears every result and arms a measurement window. The window is a programmed number of full test-clock periods.

Over the window the block collects several figures:
- the shortest and longest period;
- the largest distance of any period from a programmed nominal period;
- the largest change between two consecutive periods;
- the extremes of the high time and of the low time;
- the peak-to-peak span of the accumulated time interval error, which is the running sum of each period minus nominal.

A period below a programmed floor sets a sticky flag. A period above a programmed ceiling only increments a counter. When the last period of the window has been absorbed, a one-cycle done pulse marks the results as final. The results then hold until the next start.

Periods, limits and the window length are plain control inputs. All results are plain registered outputs, so the block has no streaming interface.

Top module: `jitter_monitor`

## Requirements
- R1: A period is the number of sampling ticks between two successive detected rising edges of the test clock. `min_period` and `max_period` report the smallest and largest periods seen in the window.
- R2: The first rising edge after `start` only sets the timing reference and is not counted. The window counts full periods. A `window` value of 0 acts as 1.
- R3: `done` is high for exactly one cycle, in the cycle in which the results of the last period of the window become visible. After `done`, all results hold until the next `start`, whatever the test clock does.
- R4: `max_dev` reports the largest value of |period - nominal| over the window.
- R5: `min_high`/`max_high` and `min_low`/`max_low` report the extremes of the high time and the low time. The high time runs from a rising edge to the next falling edge. The low time is the period minus the high time.
- R6: `max_c2c` reports the largest |P(k) - P(k-1)| over the window. The first period of a window yields no such sample, so a one-period window reports 0.
- R7: The accumulated error starts at 0 and adds (period - nominal) for each period. `tie_pp` reports the largest value of that sum minus its smallest value, with the starting 0 included in both.
- R8: `short_viol` is set by any period strictly below `min_limit` and stays set until the next `start`.
- R9: `long_count` counts the periods strictly above `max_limit`. No flag is raised for such a period.
- R10: At reset and at `start`, the min results go to all ones and every other result goes to 0. The window register takes values up to 65535, which covers runs of 10000 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | active-low asynchronous reset |
| test_clk | input | 1 | clock under test, asynchronous |
| start | input | 1 | one-cycle pulse: clear results, open a window |
| nominal | input | CNT_W | ideal period in ticks |
| window | input | WIN_W | number of full periods to observe |
| min_limit | input | CNT_W | shortest allowed period |
| max_limit | input | CNT_W | longest period not counted as long |
| min_period | output | CNT_W | shortest period |
| max_period | output | CNT_W | longest period |
| max_dev | output | CNT_W | largest distance from nominal |
| max_c2c | output | CNT_W | largest change between adjacent periods |
| min_high | output | CNT_W | shortest high time |
| max_high | output | CNT_W | longest high time |
| min_low | output | CNT_W | shortest low time |
| max_low | output | CNT_W | longest low time |
| tie_pp | output | CNT_W+WIN_W+2 | peak-to-peak accumulated error |
| long_count | output | WIN_W | number of overly long periods |
| short_viol | output | 1 | sticky short-period flag |
| done | output | 1 | one-cycle end-of-window pulse |

## Verification
The assertions assume that, after synchronization, each test-clock level lasts at least one whole sampling tick. They also assume that every period contains one falling edge, and that `start` is not raised in the same cycle as a detected rising edge. The bench holds to this by changing the test clock only on the falling edge of the sampling clock, with high and low times of one or more whole ticks. It raises `start` while the test clock has been low for several ticks. Expected figures come from the same tick counts the bench drives, across a sweep of period patterns and nominal values.

// File: rtl/jm_pkg.sv
package jm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } jm_state_e;

  parameter int JM_CNT_W_DEF = 16;
  parameter int JM_WIN_W_DEF = 16;
  parameter int JM_SYNC_DEF  = 2;
endpackage

// File: rtl/jm_sync_edge.sv
module jm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[LAST-1:0], async_in};
  end

  assign rise = shreg[LAST-1] & ~shreg[LAST];
  assign fall = ~shreg[LAST-1] & shreg[LAST];
endmodule

// File: rtl/jm_period_meas.sv
module jm_period_meas #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rise,
  input  logic             fall,
  output logic             smp_vld,
  output logic [CNT_W-1:0] smp_period,
  output logic [CNT_W-1:0] smp_high,
  output logic [CNT_W-1:0] smp_low
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] high_q;
  logic             has_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      high_q  <= '0;
      has_ref <= 1'b0;
    end else begin
      if (rise)                cnt <= ONE;
      else if (cnt != CNT_MAX) cnt <= cnt + ONE;
      if (fall) high_q <= cnt;
      if (clr)       has_ref <= 1'b0;
      else if (rise) has_ref <= 1'b1;
    end
  end

  assign smp_vld    = rise & has_ref & ~clr;
  assign smp_period = cnt;
  assign smp_high   = high_q;
  assign smp_low    = cnt - high_q;

  // R5: the high part of a period always lies strictly inside it
  p_high_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> (high_q < cnt));
endmodule

// File: rtl/jm_stats.sv
module jm_stats #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16,
  parameter int ACC_W = CNT_W + WIN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             vld,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] high,
  input  logic [CNT_W-1:0] low,
  input  logic [CNT_W-1:0] nominal,
  input  logic [CNT_W-1:0] min_limit,
  input  logic [CNT_W-1:0] max_limit,
  output logic [CNT_W-1:0] min_p,
  output logic [CNT_W-1:0] max_p,
  output logic [CNT_W-1:0] max_dev,
  output logic [CNT_W-1:0] max_c2c,
  output logic [CNT_W-1:0] min_h,
  output logic [CNT_W-1:0] max_h,
  output logic [CNT_W-1:0] min_l,
  output logic [CNT_W-1:0] max_l,
  output logic [ACC_W-1:0] tie_pp,
  output logic [WIN_W-1:0] long_cnt,
  output logic             short_flag
);
  localparam int EXT_W = ACC_W - CNT_W - 1;

  logic [CNT_W-1:0]        prev_p;
  logic                    have_prev;
  logic signed [CNT_W:0]   dev;
  logic [CNT_W-1:0]        abs_dev;
  logic [CNT_W-1:0]        c2c;
  logic signed [ACC_W-1:0] acc, acc_nxt, tie_max, tie_min;

  always_comb begin
    dev     = $signed({1'b0, period}) - $signed({1'b0, nominal});
    abs_dev = (period >= nominal) ? (period - nominal) : (nominal - period);
    c2c     = (period >= prev_p) ? (period - prev_p) : (prev_p - period);
    acc_nxt = acc + $signed({{EXT_W{dev[CNT_W]}}, dev});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_p <= '1; max_p <= '0; min_h <= '1; max_h <= '0;
      min_l <= '1; max_l <= '0; max_dev <= '0; max_c2c <= '0;
      prev_p <= '0; have_prev <= 1'b0; acc <= '0;
      tie_max <= '0; tie_min <= '0; long_cnt <= '0; short_flag <= 1'b0;
    end else if (clr) begin
      min_p <= '1; max_p <= '0; min_h <= '1; max_h <= '0;
      min_l <= '1; max_l <= '0; max_dev <= '0; max_c2c <= '0;
      prev_p <= '0; have_prev <= 1'b0; acc <= '0;
      tie_max <= '0; tie_min <= '0; long_cnt <= '0; short_flag <= 1'b0;
    end else if (vld) begin
      if (period < min_p)   min_p   <= period;
      if (period > max_p)   max_p   <= period;
      if (high < min_h)     min_h   <= high;
      if (high > max_h)     max_h   <= high;
      if (low < min_l)      min_l   <= low;
      if (low > max_l)      max_l   <= low;
      if (abs_dev > max_dev) max_dev <= abs_dev;
      if (have_prev && (c2c > max_c2c)) max_c2c <= c2c;
      prev_p    <= period;
      have_prev <= 1'b1;
      acc       <= acc_nxt;
      if (acc_nxt > tie_max) tie_max <= acc_nxt;
      if (acc_nxt < tie_min) tie_min <= acc_nxt;
      if (period > max_limit) long_cnt <= long_cnt + WIN_W'(1);
      if (period < min_limit) short_flag <= 1'b1;
    end
  end

  assign tie_pp = tie_max - tie_min;

  // R1: once a period was absorbed the extremes are ordered
  p_period_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    have_prev |-> (min_p <= max_p));
  // R6: the first period of a window never moves the adjacent-change result
  p_c2c_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !have_prev && !clr) |=> $stable(max_c2c));
  // R7: the error span can only widen inside a window
  p_tie_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !clr) |=> (tie_pp >= $past(tie_pp)));
  // R8: the short-period flag stays set until cleared
  p_short_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (short_flag && !clr) |=> short_flag);
  // R9: the long counter moves only with an absorbed period
  p_long_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !vld) |=> $stable(long_cnt));
endmodule

// File: rtl/jitter_monitor.sv
module jitter_monitor
  import jm_pkg::*;
#(
  parameter int CNT_W = JM_CNT_W_DEF,
  parameter int WIN_W = JM_WIN_W_DEF,
  parameter int SYNC  = JM_SYNC_DEF,
  localparam int ACC_W = CNT_W + WIN_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_clk,
  input  logic             start,
  input  logic [CNT_W-1:0] nominal,
  input  logic [WIN_W-1:0] window,
  input  logic [CNT_W-1:0] min_limit,
  input  logic [CNT_W-1:0] max_limit,
  output logic [CNT_W-1:0] min_period,
  output logic [CNT_W-1:0] max_period,
  output logic [CNT_W-1:0] max_dev,
  output logic [CNT_W-1:0] max_c2c,
  output logic [CNT_W-1:0] min_high,
  output logic [CNT_W-1:0] max_high,
  output logic [CNT_W-1:0] min_low,
  output logic [CNT_W-1:0] max_low,
  output logic [ACC_W-1:0] tie_pp,
  output logic [WIN_W-1:0] long_count,
  output logic             short_viol,
  output logic             done
);
  logic             rise, fall, smp_vld, take;
  logic [CNT_W-1:0] smp_period, smp_high, smp_low;
  logic [WIN_W-1:0] win_cnt, win_tgt, win_nxt;
  jm_state_e        state;

  jm_sync_edge #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(test_clk), .rise(rise), .fall(fall)
  );

  jm_period_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .clr(start), .rise(rise), .fall(fall),
    .smp_vld(smp_vld), .smp_period(smp_period), .smp_high(smp_high),
    .smp_low(smp_low)
  );

  assign take    = smp_vld & (state == ST_RUN);
  assign win_tgt = (window == '0) ? WIN_W'(1) : window;
  assign win_nxt = win_cnt + WIN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      win_cnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state   <= ST_RUN;
        win_cnt <= '0;
      end else if (take) begin
        win_cnt <= win_nxt;
        if (win_nxt >= win_tgt) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  jm_stats #(.CNT_W(CNT_W), .WIN_W(WIN_W), .ACC_W(ACC_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .clr(start), .vld(take),
    .period(smp_period), .high(smp_high), .low(smp_low),
    .nominal(nominal), .min_limit(min_limit), .max_limit(max_limit),
    .min_p(min_period), .max_p(max_period), .max_dev(max_dev),
    .max_c2c(max_c2c), .min_h(min_high), .max_h(max_high),
    .min_l(min_low), .max_l(max_low), .tie_pp(tie_pp),
    .long_cnt(long_count), .short_flag(short_viol)
  );

  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: results are frozen once the window has closed
  p_hold_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> $stable(min_period) && $stable(tie_pp));
  // R2: the period count never passes the programmed window while running
  p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (win_cnt < win_tgt));
endmodule

// File: tb/jitter_monitor_tb.sv
module jitter_monitor_tb;
  localparam int CNT_W = 16;
  localparam int WIN_W = 16;
  localparam int ACC_W = CNT_W + WIN_W + 2;

  logic clk = 1'b0, rst_n = 1'b0, tclk = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] nominal = '0, min_limit = '0, max_limit = '0;
  logic [WIN_W-1:0] window = '0;
  logic [CNT_W-1:0] min_period, max_period, max_dev, max_c2c;
  logic [CNT_W-1:0] min_high, max_high, min_low, max_low;
  logic [ACC_W-1:0] tie_pp;
  logic [WIN_W-1:0] long_count;
  logic short_viol, done;

  int checks = 0, errs = 0, done_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  jitter_monitor #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .test_clk(tclk), .start(start),
    .nominal(nominal), .window(window), .min_limit(min_limit),
    .max_limit(max_limit), .min_period(min_period), .max_period(max_period),
    .max_dev(max_dev), .max_c2c(max_c2c), .min_high(min_high),
    .max_high(max_high), .min_low(min_low), .max_low(max_low),
    .tie_pp(tie_pp), .long_count(long_count), .short_viol(short_viol),
    .done(done)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int hi_f(int mode, int k);
    case (mode)
      0: return 3;
      1: return 3 + (k * 7) % 5;
      2: return 4 + ((k % 3 == 0) ? 1 : 0);
      default: return 4;
    endcase
  endfunction

  function automatic int lo_f(int mode, int k);
    case (mode)
      0: return 3;
      1: return 4 + (k * 3) % 4;
      2: return 5 + ((k < 15) ? 1 : 0);
      default: return (k == 2) ? 1 : 6;
    endcase
  endfunction

  task automatic run_case(int mode, int nom, int win, int minl, int maxl);
    int weff = (win == 0) ? 1 : win;
    longint emin = 65535, emax = 0, edev = 0, ec2c = 0, ehmin = 65535, ehmax = 0;
    longint elmin = 65535, elmax = 0, acc = 0, tmax = 0, tmin = 0, elong = 0;
    longint eshort = 0, prevp = 0;
    int d0;
    for (int k = 0; k < weff; k++) begin
      longint h = hi_f(mode, k), l = lo_f(mode, k), p;
      p = h + l;
      if (p < emin) emin = p;
      if (p > emax) emax = p;
      if (h < ehmin) ehmin = h;
      if (h > ehmax) ehmax = h;
      if (l < elmin) elmin = l;
      if (l > elmax) elmax = l;
      if (((p > nom) ? p - nom : nom - p) > edev) edev = (p > nom) ? p - nom : nom - p;
      if (k > 0 && ((p > prevp) ? p - prevp : prevp - p) > ec2c)
        ec2c = (p > prevp) ? p - prevp : prevp - p;
      prevp = p;
      acc += p - nom;
      if (acc > tmax) tmax = acc;
      if (acc < tmin) tmin = acc;
      if (p > maxl) elong++;
      if (p < minl) eshort = 1;
    end
    @(negedge clk);
    nominal = CNT_W'(nom); window = WIN_W'(win);
    min_limit = CNT_W'(minl); max_limit = CNT_W'(maxl);
    tclk = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    d0 = done_cnt;
    repeat (4) @(negedge clk);
    for (int k = 0; k <= weff; k++) begin
      tclk = 1'b1;
      repeat (hi_f(mode, k)) @(negedge clk);
      tclk = 1'b0;
      repeat (lo_f(mode, k)) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R3 done pulses", done_cnt - d0, 1);
    chk("R1 min_period", min_period, emin);
    chk("R1 max_period", max_period, emax);
    chk("R4 max_dev", max_dev, edev);
    chk("R5 min_high", min_high, ehmin);
    chk("R5 max_high", max_high, ehmax);
    chk("R5 min_low", min_low, elmin);
    chk("R5 max_low", max_low, elmax);
    chk("R6 max_c2c", max_c2c, ec2c);
    chk("R7 tie_pp", tie_pp, tmax - tmin);
    chk("R9 long_count", long_count, elong);
    chk("R8 short_viol", short_viol, eshort);
    // R3: extra fast test-clock periods after done must not alter anything
    for (int k = 0; k < 5; k++) begin
      tclk = 1'b1; repeat (1) @(negedge clk);
      tclk = 1'b0; repeat (1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R3 hold min_period", min_period, emin);
    chk("R3 hold max_c2c", max_c2c, ec2c);
    chk("R3 hold tie_pp", tie_pp, tmax - tmin);
    chk("R3 no extra done", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset min_period", min_period, 65535);
    chk("R10 reset max_period", max_period, 0);
    chk("R10 reset tie_pp", tie_pp, 0);
    chk("R10 reset done", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: a 10000-period window of a clean 6-tick clock
    run_case(0, 6, 10000, 5, 6);
    // sweep of patterns and nominal values
    for (int m = 1; m <= 3; m++)
      for (int n = 8; n <= 12; n++)
        run_case(m, n, 30, 7, 12);
    // R6 / R10: one-period window after a noisy run: start clears, no c2c
    run_case(1, 10, 1, 7, 12);
    // R2: window 0 acts as a single period
    run_case(3, 10, 0, 7, 12);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule